// File: doc/BRIEF.md
# Raster Position Counter Generator

This block keeps the current pixel position within a line and the current line position within a field for a sensor timing generator. It runs on the master pixel clock. Downstream edge-placement logic compares the exported counts against its own programmed positions. It runs in one of two modes:

- **Master mode.** The block sets the line and field periods from configuration inputs and drives its own horizontal and vertical sync pulses. An active-low sync input restarts both counters.
- **Slave mode.** The block follows externally supplied horizontal and vertical sync inputs. Each input passes through a two-flop synchroniser, and a rising edge realigns the counters.

Edge positions can only be programmed up to 8191, but lines can be longer. A flag therefore reports when the pixel count has gone past that limit. Sampling keeps running past that point. In slave mode the pixel counter stops at its 14-bit ceiling rather than wrapping, so lines of any length can be followed.

Top module: `raster_timing_core`

## Requirements
- R1: While `rst` is high at a clock edge, both counts go to 0 and `hd_out`, `vd_out` and `h_beyond` go low.
- R2: In master mode (`mode_slave`=0) with `sync_n` high, `h_count` rises by one per clock. After reaching `cfg_line_last` it returns to 0, and on that wrap `v_count` rises by one.
- R3: In master mode, a wrap of `h_count` with `v_count` at or above `cfg_field_last` returns `v_count` to 0.
- R4: In master mode, from the first clock after reset, `hd_out` is high exactly while `h_count` < `cfg_hd_width`. Likewise, `vd_out` is high exactly while `v_count` < `cfg_vd_width`.
- R5: In master mode, `sync_n` sampled low at an edge clears both counts at that edge. This takes precedence over a line or field wrap in the same cycle.
- R6: In slave mode, a rising `hd_in` first sampled at edge k clears `h_count` to 0 and raises `v_count` by one at edge k+2.
- R7: In slave mode, a rising `vd_in` first sampled at edge k clears `v_count` at edge k+2 while `h_count` keeps counting. When it coincides with an `hd_in` rise, `v_count` ends at 0 and `h_count` ends at 0.
- R8: In slave mode, `h_count` holds at 16383 instead of wrapping until an `hd_in` rise arrives.
- R9: In slave mode, `hd_out` and `vd_out` stay low and `sync_n` has no effect on the counts.
- R10: `h_beyond` is high exactly while `h_count` exceeds 8191.
- R11: In master mode, transitions on `hd_in` and `vd_in` have no effect on the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_slave | input | 1 | 0 = master (own timing), 1 = slave (follow inputs) |
| sync_n | input | 1 | Active-low counter restart, master mode only |
| hd_in | input | 1 | External horizontal sync, slave mode |
| vd_in | input | 1 | External vertical sync, slave mode |
| cfg_line_last | input | 14 | Pixels per line minus one (master) |
| cfg_field_last | input | 13 | Lines per field minus one (master) |
| cfg_hd_width | input | 14 | Horizontal pulse width in pixels (master) |
| cfg_vd_width | input | 13 | Vertical pulse width in lines (master) |
| hd_out | output | 1 | Generated horizontal sync pulse |
| vd_out | output | 1 | Generated vertical sync pulse |
| h_count | output | 14 | Current pixel position |
| v_count | output | 13 | Current line position |
| h_beyond | output | 1 | Pixel position is past the programmable range |

## Verification
Two pairs of events can land in the same clock, and the bench provokes both deliberately.

- **Restart against end of line and field.** In master mode, `sync_n` is pulled low exactly at the pixel where the line would wrap and the line counter would step. The bench judges the outcome by requiring both counts to read 0 rather than the advanced line number.
- **Both external syncs together.** In slave mode, `hd_in` and `vd_in` are raised together so that their synchronised edges coincide. The bench confirms that the line count lands on 0, not 1, while the pixel count also clears.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int HCNT_W     = 14;
    localparam int VCNT_W     = 13;
    localparam int PROG_LIMIT = 8191;
    localparam int SYNC_STAGES = 2;

    localparam logic [HCNT_W-1:0] H_MAX = {HCNT_W{1'b1}};

    typedef logic [HCNT_W-1:0] hcnt_t;
    typedef logic [VCNT_W-1:0] vcnt_t;

    typedef enum logic {
        MODE_MASTER = 1'b0,
        MODE_SLAVE  = 1'b1
    } mode_e;

    typedef struct packed {
        logic restart;
        logic hd_edge;
        logic vd_edge;
    } evt_t;

    function automatic hcnt_t h_step_sat(hcnt_t c);
        return (c == H_MAX) ? H_MAX : c + hcnt_t'(1);
    endfunction

endpackage

// File: rtl/rlc_edge_sync.sv
module rlc_edge_sync #(
    parameter int STAGES = raster_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], din};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/rlc_hcount.sv
module rlc_hcount
    import raster_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  evt_t  evt,
    input  hcnt_t line_last,
    output hcnt_t hcnt,
    output hcnt_t hnxt,
    output logic  line_adv
);
    always_comb begin
        line_adv = 1'b0;
        hnxt     = hcnt;
        if (mode == MODE_MASTER) begin
            if (evt.restart) begin
                hnxt = '0;
            end else if (hcnt >= line_last) begin
                hnxt     = '0;
                line_adv = 1'b1;
            end else begin
                hnxt = hcnt + hcnt_t'(1);
            end
        end else begin
            if (evt.hd_edge) begin
                hnxt     = '0;
                line_adv = 1'b1;
            end else begin
                hnxt = h_step_sat(hcnt);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hcnt <= '0;
        else     hcnt <= hnxt;
    end
endmodule

// File: rtl/rlc_vcount.sv
module rlc_vcount
    import raster_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  evt_t  evt,
    input  logic  line_adv,
    input  vcnt_t field_last,
    output vcnt_t vcnt,
    output vcnt_t vnxt
);
    always_comb begin
        vnxt = vcnt;
        if (mode == MODE_MASTER) begin
            if (evt.restart)
                vnxt = '0;
            else if (line_adv)
                vnxt = (vcnt >= field_last) ? '0 : vcnt + vcnt_t'(1);
        end else begin
            if (evt.vd_edge)
                vnxt = '0;
            else if (line_adv)
                vnxt = vcnt + vcnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vcnt <= '0;
        else     vcnt <= vnxt;
    end
endmodule

// File: rtl/rlc_pulse_gen.sv
module rlc_pulse_gen
    import raster_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  hcnt_t hnxt,
    input  vcnt_t vnxt,
    input  hcnt_t hd_width,
    input  vcnt_t vd_width,
    output logic  hd_out,
    output logic  vd_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hd_out <= 1'b0;
            vd_out <= 1'b0;
        end else begin
            hd_out <= (mode == MODE_MASTER) && (hnxt < hd_width);
            vd_out <= (mode == MODE_MASTER) && (vnxt < vd_width);
        end
    end
endmodule

// File: rtl/raster_timing_core.sv
module raster_timing_core
    import raster_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_slave,
    input  logic        sync_n,
    input  logic        hd_in,
    input  logic        vd_in,
    input  logic [13:0] cfg_line_last,
    input  logic [12:0] cfg_field_last,
    input  logic [13:0] cfg_hd_width,
    input  logic [12:0] cfg_vd_width,
    output logic        hd_out,
    output logic        vd_out,
    output logic [13:0] h_count,
    output logic [12:0] v_count,
    output logic        h_beyond
);
    mode_e mode;
    evt_t  evt;
    logic  hd_rise, vd_rise, line_adv;
    hcnt_t hcnt, hnxt;
    vcnt_t vcnt, vnxt;

    assign mode = mode_slave ? MODE_SLAVE : MODE_MASTER;

    rlc_edge_sync #(.STAGES(SYNC_STAGES)) i_hd_sync (
        .clk(clk), .rst(rst), .din(hd_in), .rise(hd_rise));
    rlc_edge_sync #(.STAGES(SYNC_STAGES)) i_vd_sync (
        .clk(clk), .rst(rst), .din(vd_in), .rise(vd_rise));

    always_comb begin
        evt.restart = (mode == MODE_MASTER) && !sync_n;
        evt.hd_edge = (mode == MODE_SLAVE) && hd_rise;
        evt.vd_edge = (mode == MODE_SLAVE) && vd_rise;
    end

    rlc_hcount i_hcount (
        .clk(clk), .rst(rst), .mode(mode), .evt(evt),
        .line_last(cfg_line_last), .hcnt(hcnt), .hnxt(hnxt),
        .line_adv(line_adv));

    rlc_vcount i_vcount (
        .clk(clk), .rst(rst), .mode(mode), .evt(evt),
        .line_adv(line_adv), .field_last(cfg_field_last),
        .vcnt(vcnt), .vnxt(vnxt));

    rlc_pulse_gen i_pulse (
        .clk(clk), .rst(rst), .mode(mode), .hnxt(hnxt), .vnxt(vnxt),
        .hd_width(cfg_hd_width), .vd_width(cfg_vd_width),
        .hd_out(hd_out), .vd_out(vd_out));

    assign h_count  = hcnt;
    assign v_count  = vcnt;
    assign h_beyond = hcnt > hcnt_t'(PROG_LIMIT);
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
    import raster_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        mode_slave,
    input logic        sync_n,
    input logic        hd_rise,
    input logic        vd_rise,
    input logic [13:0] cfg_line_last,
    input logic        hd_out,
    input logic        vd_out,
    input logic [13:0] h_count,
    input logic [12:0] v_count,
    input logic        h_beyond
);
    AST_MASTER_STEP: assert property (@(posedge clk) disable iff (rst)
        (!mode_slave && sync_n && h_count < cfg_line_last) |=> h_count == $past(h_count) + 14'd1); // R2
    AST_MASTER_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!mode_slave && sync_n && h_count >= cfg_line_last) |=> h_count == 14'd0); // R2
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!mode_slave && !sync_n) |=> (h_count == 14'd0 && v_count == 13'd0)); // R5
    AST_HD_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (mode_slave && hd_rise) |=> h_count == 14'd0); // R6
    AST_VD_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (mode_slave && vd_rise) |=> v_count == 13'd0); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (mode_slave && h_count == H_MAX && !hd_rise) |=> h_count == H_MAX); // R8
    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        mode_slave |=> (!hd_out && !vd_out)); // R9
    AST_BEYOND_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(h_beyond) |-> h_count == 14'(PROG_LIMIT + 1)); // R10
endmodule

bind raster_timing_core raster_timing_chk i_chk (
    .clk(clk), .rst(rst), .mode_slave(mode_slave), .sync_n(sync_n),
    .hd_rise(hd_rise), .vd_rise(vd_rise), .cfg_line_last(cfg_line_last),
    .hd_out(hd_out), .vd_out(vd_out), .h_count(h_count),
    .v_count(v_count), .h_beyond(h_beyond));

// File: tb/test_raster_timing_core.sv
`timescale 1ns/1ps
module test_raster_timing_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_slave = 1'b0;
    logic        sync_n = 1'b1;
    logic        hd_in = 1'b0;
    logic        vd_in = 1'b0;
    logic [13:0] cfg_line_last = 14'd9;
    logic [12:0] cfg_field_last = 13'd4;
    logic [13:0] cfg_hd_width = 14'd3;
    logic [12:0] cfg_vd_width = 13'd2;
    logic        hd_out, vd_out, h_beyond;
    logic [13:0] h_count;
    logic [12:0] v_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    raster_timing_core i_raster_timing_core (
        .clk(clk), .rst(rst), .mode_slave(mode_slave), .sync_n(sync_n),
        .hd_in(hd_in), .vd_in(vd_in), .cfg_line_last(cfg_line_last),
        .cfg_field_last(cfg_field_last), .cfg_hd_width(cfg_hd_width),
        .cfg_vd_width(cfg_vd_width), .hd_out(hd_out), .vd_out(vd_out),
        .h_count(h_count), .v_count(v_count), .h_beyond(h_beyond));

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic slave);
        rst = 1'b1; mode_slave = slave; sync_n = 1'b1; hd_in = 1'b0; vd_in = 1'b0;
        step(3);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; mode_slave = 1'b0;
        step(3);
        check("R1 h_count", h_count, 0);
        check("R1 v_count", v_count, 0);
        check("R1 hd_out", hd_out, 0);
        check("R1 vd_out", vd_out, 0);
        check("R1 h_beyond", h_beyond, 0);
        rst = 1'b0;
    endtask

    task automatic t_master_run;
        for (int n = 1; n <= 120; n++) begin
            step(1);
            check("R2 h_count", h_count, n % 10);
            check("R3 v_count", v_count, (n / 10) % 5);
            check("R4 hd_out", hd_out, int'((n % 10) < 3));
            check("R4 vd_out", vd_out, int'(((n / 10) % 5) < 2));
        end
    endtask

    task automatic t_master_restart;
        check("R2 pre h", h_count, 0);
        check("R2 pre v", v_count, 2);
        sync_n = 1'b0;
        step(1);
        check("R5 h", h_count, 0);
        check("R5 v", v_count, 0);
        check("R5 hd_out", hd_out, 1);
        step(2);
        check("R5 held h", h_count, 0);
        sync_n = 1'b1;
        step(29);
        check("R2 h before wrap", h_count, 9);
        check("R2 v before wrap", v_count, 2);
        sync_n = 1'b0;
        step(1);
        check("R5 collide h", h_count, 0);
        check("R5 collide v", v_count, 0);
        sync_n = 1'b1;
        step(1);
        check("R5 resume h", h_count, 1);
    endtask

    task automatic t_master_ignores_inputs;
        hd_in = 1'b1; vd_in = 1'b1;
        step(6);
        check("R11 h", h_count, 7);
        check("R11 v", v_count, 0);
        hd_in = 1'b0; vd_in = 1'b0;
        step(3);
        check("R11 wrap h", h_count, 0);
        check("R11 wrap v", v_count, 1);
    endtask

    task automatic t_slave_edges;
        do_reset(1'b1);
        step(20);
        check("R9 free h", h_count, 20);
        check("R9 hd_out", hd_out, 0);
        check("R9 vd_out", vd_out, 0);
        hd_in = 1'b1;
        step(2);
        check("R6 latency h", h_count, 22);
        step(1);
        check("R6 h", h_count, 0);
        check("R6 v", v_count, 1);
        step(5);
        check("R6 run h", h_count, 5);
        hd_in = 1'b0;
        step(3);
        hd_in = 1'b1;
        step(3);
        check("R6 second v", v_count, 2);
        hd_in = 1'b0;
        step(4);
        check("R6 h after", h_count, 4);
        hd_in = 1'b1; vd_in = 1'b1;
        step(3);
        check("R7 both h", h_count, 0);
        check("R7 both v", v_count, 0);
        hd_in = 1'b0; vd_in = 1'b0;
        step(4);
        hd_in = 1'b1;
        step(3);
        check("R6 v again", v_count, 1);
        hd_in = 1'b0;
        step(2);
        vd_in = 1'b1;
        step(3);
        check("R7 vd alone v", v_count, 0);
        check("R7 vd alone h", h_count, 5);
        vd_in = 1'b0;
        sync_n = 1'b0;
        step(4);
        check("R9 sync ignored h", h_count, 9);
        check("R9 sync ignored v", v_count, 0);
        check("R9 hd_out", hd_out, 0);
        sync_n = 1'b1;
    endtask

    task automatic t_slave_saturate;
        do_reset(1'b1);
        step(8191);
        check("R10 h at limit", h_count, 8191);
        check("R10 not beyond", h_beyond, 0);
        step(1);
        check("R10 h past limit", h_count, 8192);
        check("R10 beyond", h_beyond, 1);
        step(8191);
        check("R8 h at max", h_count, 16383);
        step(10);
        check("R8 h held", h_count, 16383);
        check("R10 still beyond", h_beyond, 1);
        hd_in = 1'b1;
        step(3);
        check("R8 h released", h_count, 0);
        check("R10 back in range", h_beyond, 0);
        check("R6 v step", v_count, 1);
        hd_in = 1'b0;
    endtask

    initial begin
        t_reset();
        t_master_run();
        t_master_restart();
        t_master_ignores_inputs();
        t_slave_edges();
        t_slave_saturate();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule